// File: doc/BRIEF.md
# Sideways Tile Remap Controller

This block tracks where each of N_LOG logical tiles of an application is placed in a single row of N_PHYS physical tiles. N_PHYS is at least N_LOG, and the extra tiles at the high-index end of the row serve as spares. When a checker reports that a physical tile has failed, the whole tile is marked bad. Every logical tile sitting on that tile or further along the row then slides one good position toward the spare end. After the move, logical tile i occupies the i-th good physical tile of the row.

Links between neighbouring logical tiles follow the tiles in the same direction. For each link the block reports its span: how many physical positions separate the two ends. Routing at the tile edges can use that span as a select. Wiring inside a tile moves with the tile and needs no output. When a report would leave fewer good tiles than logical tiles, the block raises a sticky flag and freezes the placement table.

Top module: `tile_remap`

## Requirements
- R1: After reset, logical tile i is placed on physical tile i and every link span is 1. The bad mask is all zero, and no_spare and remap_done are 0.
- R2: A fault report (fault_valid high for one cycle, fault_idx below N_PHYS) names a physical tile that holds a logical tile. The outputs change on the clock edge that samples the report. The tile's bad_mask bit is set. Every logical tile on that tile or beyond moves to the next good physical tile toward the high-index end, and tiles below it stay where they are.
- R3: While no_spare is 0, logical tile i sits on the i-th good physical tile, counting from 0. No logical tile is ever placed on a tile whose bad_mask bit is 1.
- R4: A report naming a spare tile, or a tile already marked bad, only sets the bad_mask bit. tile_map stays unchanged.
- R5: Field i of tile_map is bits [i*IW +: IW], with IW = $clog2(N_PHYS). Field i of link_span equals map[i+1] - map[i], at the same bit position.
- R6: A report that leaves fewer than N_LOG good tiles raises no_spare. tile_map keeps its previous value, no remap_done pulse follows, and bad_mask still records the tile. no_spare stays 1 until reset.
- R7: A report with fault_idx of N_PHYS or more is ignored: bad_mask, tile_map and no_spare are unchanged and remap_done stays 0.
- R8: A bit of bad_mask never returns to 0 except through reset.
- R9: remap_done is high for exactly the one cycle after each in-range report that does not end in no_spare. This includes reports on spare or already-bad tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_valid | input | 1 | Fault report strobe |
| fault_idx | input | IW | Physical tile named by the report |
| tile_map | output | N_LOG*IW | Physical position of each logical tile |
| link_span | output | (N_LOG-1)*IW | Physical distance covered by each inter-tile link |
| bad_mask | output | N_PHYS | One bit per physical tile, 1 = excluded |
| no_spare | output | 1 | Sticky: too few good tiles remain |
| remap_done | output | 1 | One-cycle pulse after an accepted report |

## Verification
Most faults in the placement or mask state show up on the cycle right after the report. A stale mask or a wrong popcount puts a logical tile on a bad tile, or leaves the low tiles shifted when they should not move. Either way the expected table and the link spans disagree at once. A wrong good-tile count shows up as no_spare rising one report too early or too late. A lost strobe shows up as a missing or doubled remap_done. The bench therefore compares the whole table, the spans, the mask and both flags after every report.

// File: rtl/tile_remap_pkg.sv
package tile_remap_pkg;
  localparam int MAX_TILES = 32;

  // number of zero (good) bits among the lowest m bits
  function automatic int good_count(input logic [MAX_TILES-1:0] bad, input int m);
    int c;
    c = 0;
    for (int p = 0; p < MAX_TILES; p++)
      if (p < m && !bad[p]) c++;
    return c;
  endfunction

  // position of the n-th good tile (0-based); m when there is none
  function automatic int nth_good(input logic [MAX_TILES-1:0] bad, input int m, input int n);
    int seen;
    int pos;
    seen = 0;
    pos  = m;
    for (int p = 0; p < MAX_TILES; p++) begin
      if (p < m && !bad[p]) begin
        if (seen == n && pos == m) pos = p;
        seen++;
      end
    end
    return pos;
  endfunction
endpackage

// File: rtl/tile_fault_mask.sv
module tile_fault_mask #(
  parameter int N_PHYS = 6,
  parameter int IW     = $clog2(N_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [IW-1:0]     fault_idx,
  output logic [N_PHYS-1:0] mask_q,
  output logic [N_PHYS-1:0] mask_next,
  output int                good_next
);
  import tile_remap_pkg::*;

  always_comb begin
    mask_next = mask_q;
    if (accept) mask_next = mask_q | (N_PHYS'(1) << fault_idx);
    good_next = good_count(MAX_TILES'(mask_next), N_PHYS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next;
  end
endmodule

// File: rtl/tile_placer.sv
module tile_placer #(
  parameter int N_LOG  = 4,
  parameter int N_PHYS = 6,
  parameter int IW     = $clog2(N_PHYS)
) (
  input  logic [N_PHYS-1:0]   bad,
  output logic [N_LOG*IW-1:0] place
);
  import tile_remap_pkg::*;

  for (genvar i = 0; i < N_LOG; i++) begin : g_slot
    always_comb place[i*IW +: IW] = IW'(nth_good(MAX_TILES'(bad), N_PHYS, i));
  end
endmodule

// File: rtl/tile_link_span.sv
module tile_link_span #(
  parameter int N_LOG = 4,
  parameter int IW    = 3
) (
  input  logic [N_LOG*IW-1:0]     place,
  output logic [(N_LOG-1)*IW-1:0] span
);
  for (genvar i = 0; i < N_LOG - 1; i++) begin : g_link
    always_comb span[i*IW +: IW] = place[(i+1)*IW +: IW] - place[i*IW +: IW];
  end
endmodule

// File: rtl/tile_remap.sv
module tile_remap #(
  parameter int N_LOG  = 4,
  parameter int N_PHYS = 6,
  localparam int IW    = $clog2(N_PHYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fault_valid,
  input  logic [IW-1:0]           fault_idx,
  output logic [N_LOG*IW-1:0]     tile_map,
  output logic [(N_LOG-1)*IW-1:0] link_span,
  output logic [N_PHYS-1:0]       bad_mask,
  output logic                    no_spare,
  output logic                    remap_done
);
  logic                accept;
  logic [N_PHYS-1:0]   mask_next;
  int                  good_next;
  logic                short_next;
  logic [N_LOG*IW-1:0] place_next;
  logic [N_LOG*IW-1:0] map_q;
  logic                nsp_q;
  logic                done_q;

  assign accept     = fault_valid && ({1'b0, fault_idx} < (IW+1)'(N_PHYS));
  assign short_next = good_next < N_LOG;

  tile_fault_mask #(.N_PHYS(N_PHYS), .IW(IW)) u_mask (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fault_idx(fault_idx),
    .mask_q(bad_mask), .mask_next(mask_next), .good_next(good_next)
  );

  tile_placer #(.N_LOG(N_LOG), .N_PHYS(N_PHYS), .IW(IW)) u_place (
    .bad(mask_next), .place(place_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LOG; i++) map_q[i*IW +: IW] <= IW'(i);
      nsp_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept && !short_next;
      if (accept) begin
        if (short_next) nsp_q <= 1'b1;
        else            map_q <= place_next;
      end
    end
  end

  tile_link_span #(.N_LOG(N_LOG), .IW(IW)) u_span (
    .place(map_q), .span(link_span)
  );

  assign tile_map   = map_q;
  assign no_spare   = nsp_q;
  assign remap_done = done_q;
endmodule

// File: rtl/tile_remap_chk.sv
module tile_remap_chk #(
  parameter int N_LOG  = 4,
  parameter int N_PHYS = 6,
  parameter int IW     = $clog2(N_PHYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fault_valid,
  input logic [IW-1:0]       fault_idx,
  input logic [N_LOG*IW-1:0] tile_map,
  input logic [N_PHYS-1:0]   bad_mask,
  input logic                no_spare,
  input logic                remap_done,
  input logic                accept
);
  for (genvar i = 0; i < N_LOG; i++) begin : g_good
    assert_on_good_tile_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !no_spare |-> !bad_mask[tile_map[i*IW +: IW]]);
  end

  assert_spare_fault_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_idx > tile_map[(N_LOG-1)*IW +: IW]) |=> $stable(tile_map));

  assert_freeze_on_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_spare) |-> ($stable(tile_map) && !remap_done));

  assert_sticky_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_spare |=> no_spare);

  assert_ignore_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !accept) |=> ($stable(bad_mask) && $stable(tile_map) && !remap_done));

  assert_mask_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bad_mask & $past(bad_mask)) == $past(bad_mask)));

  assert_done_follows_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
    remap_done |-> $past(accept));
endmodule

bind tile_remap tile_remap_chk #(.N_LOG(N_LOG), .N_PHYS(N_PHYS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_idx(fault_idx),
  .tile_map(tile_map), .bad_mask(bad_mask), .no_spare(no_spare),
  .remap_done(remap_done), .accept(accept)
);

// File: tb/tile_remap_tb.sv
`timescale 1ns/1ps
module tile_remap_tb;
  localparam int NL = 4;
  localparam int NP = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_valid = 1'b0;
  logic [IW-1:0] fault_idx = '0;
  logic [NL*IW-1:0] tile_map;
  logic [(NL-1)*IW-1:0] link_span;
  logic [NP-1:0] bad_mask;
  logic no_spare, remap_done;

  int total = 0;
  int bad = 0;
  logic [NP-1:0] exp_mask;

  always #4 clk = ~clk;

  tile_remap #(.N_LOG(NL), .N_PHYS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_idx(fault_idx),
    .tile_map(tile_map), .link_span(link_span), .bad_mask(bad_mask),
    .no_spare(no_spare), .remap_done(remap_done)
  );

  typedef struct packed {
    logic [2:0] idx;
    logic [2:0] m0, m1, m2, m3;
    logic       ns;
    logic       dn;
  } vec_t;

  // sequence from reset: mapped fault, mapped fault, out of range,
  // repeat fault, exhausting fault, fault after exhaustion
  localparam vec_t VECS [6] = '{
    '{3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 1'b0, 1'b1},
    '{3'd3, 3'd0, 3'd2, 3'd4, 3'd5, 1'b0, 1'b1},
    '{3'd7, 3'd0, 3'd2, 3'd4, 3'd5, 1'b0, 1'b0},
    '{3'd3, 3'd0, 3'd2, 3'd4, 3'd5, 1'b0, 1'b1},
    '{3'd0, 3'd0, 3'd2, 3'd4, 3'd5, 1'b1, 1'b0},
    '{3'd5, 3'd0, 3'd2, 3'd4, 3'd5, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fault_valid = 1'b0;
    exp_mask = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one-cycle report; returns at the negedge after the sampling edge
  task automatic report(input int idx);
    @(negedge clk);
    fault_valid = 1'b1;
    fault_idx = IW'(idx);
    @(negedge clk);
    fault_valid = 1'b0;
    if (idx < NP) exp_mask[idx] = 1'b1;
  endtask

  task automatic check_table(input string req, input int a, input int b, input int c, input int d);
    int e[NL];
    e = '{a, b, c, d};
    for (int i = 0; i < NL; i++) check({req, " map"}, int'(tile_map[i*IW +: IW]), e[i]);
    for (int i = 0; i < NL - 1; i++)
      check("R5 span", int'(link_span[i*IW +: IW]), e[i+1] - e[i]);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check_table("R1", 0, 1, 2, 3);
    check("R1 mask", int'(bad_mask), 0);
    check("R1 no_spare", int'(no_spare), 0);
    check("R1 done", int'(remap_done), 0);

    // table walk: R2 shift, R7 ignore, R4 repeat, R6 exhaustion
    foreach (VECS[k]) begin
      report(int'(VECS[k].idx));
      check_table("R2/R3", int'(VECS[k].m0), int'(VECS[k].m1), int'(VECS[k].m2), int'(VECS[k].m3));
      check("R8 mask", int'(bad_mask), int'(exp_mask));
      check("R6 no_spare", int'(no_spare), int'(VECS[k].ns));
      check("R9 done", int'(remap_done), int'(VECS[k].dn));
      @(negedge clk);
      check("R9 done pulse ends", int'(remap_done), 0);
    end

    // R4: spare faults keep the table, then R6 at exactly N_LOG good
    do_reset();
    report(5);
    check_table("R4", 0, 1, 2, 3);
    check("R4 done", int'(remap_done), 1);
    check("R4 mask", int'(bad_mask), 32);
    report(4);
    check_table("R4", 0, 1, 2, 3);
    check("R6 still enough", int'(no_spare), 0);
    report(0);
    check("R6 raised", int'(no_spare), 1);
    check_table("R6 frozen", 0, 1, 2, 3);
    check("R6 mask records", int'(bad_mask), 49);
    check("R6 no done", int'(remap_done), 0);

    // R2: fault on the last mapped tile only moves that tile
    do_reset();
    report(3);
    check_table("R2 last", 0, 1, 2, 4);
    check("R2 done", int'(remap_done), 1);
    // R2/R3: fault on tile 0 shifts all
    report(0);
    check_table("R3 all", 1, 2, 4, 5);
    // R7: idx 6 out of range
    report(6);
    check_table("R7", 1, 2, 4, 5);
    check("R7 mask", int'(bad_mask), 9);
    check("R7 done", int'(remap_done), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule